// File: doc/BRIEF.md
# Clockwise Transposition Mesh Router

This block moves address-only packets across a two-dimensional grid of nodes until each one reaches the node it names. Every node holds either nothing (null) or one packet. A packet is a target row and a target column. Routing is done only by compare-exchange between adjacent nodes. One clock cycle is one phase, and a fixed schedule of four phases repeats. Within a phase all the compared pairs are disjoint and update at the same time. Two packets with identical targets that meet in a compared pair cancel each other. A packet that sits on its own target node is removed, and a one-cycle arrival pulse is raised at that node.

Per-node disabled-neighbour bits let a defective area be walled off. An exchange toward a disabled neighbour never happens. When a node has a disabled neighbour on one axis, exchanges along the other axis are forced, so that packets are steered around the wall.

The host loads every node in parallel, pulses start, and waits for done. Done rises when the grid is empty or when a step limit is reached. The remaining packets can then be read from the per-node outputs.

Top module: `ctr_mesh_router`

## Requirements
- R1: After reset every node holds null, `done_o` is low and `arrive_o` is all zero.
- R2: A `load_i` pulse while idle captures a packet and four disabled bits for each node and clears `done_o`. Node index is row*COLS+column, with row 0 at the top. The disabled bits are bit0 for the node above, bit1 for the right, bit2 for below and bit3 for the left.
- R3: The run steps through four phases in this order: odd rows with the row above, odd columns with the column to the right, odd rows with the row below, odd columns with the column to the left. Rows and columns are counted from 0.
- R4: When both nodes of a pair hold packets, they swap exactly when the target coordinate of the packet in the lower-index node (along the tested axis) is greater than that of the other packet. Vertical pairs compare rows and horizontal pairs compare columns.
- R5: When only one node of a pair holds a packet, that packet moves across the pair only if the move brings it closer to its target coordinate on that axis.
- R6: Two packets with identical row and column targets that are compared in a pair both become null. No packet is ever created.
- R7: At each step, a packet that is already on its target node is removed before the exchange, and `arrive_o` for that node is high for the following cycle. Each packet arrives exactly once.
- R8: A pair in which either node marks the other as disabled performs neither a swap nor a cancellation.
- R9: A pair is forced to swap when either of its nodes has a disabled neighbour on the axis orthogonal to the pair.
- R10: When a step leaves every node null, `done_o` rises on the next cycle and the run ends.
- R11: If packets remain after MAX_STEPS steps, `done_o` rises on the following cycle and the leftover packets stay readable.
- R12: `load_i` and `start_i` are ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load strobe |
| ld_valid_i | input | N | Per-node packet present flag for the load |
| ld_row_i | input | N*RW | Per-node target row for the load |
| ld_col_i | input | N*CW | Per-node target column for the load |
| ld_dis_i | input | 4*N | Per-node disabled-neighbour bits |
| start_i | input | 1 | Begin a routing run |
| done_o | output | 1 | Run finished; held until the next load or start |
| pkt_valid_o | output | N | Per-node packet present |
| pkt_row_o | output | N*RW | Per-node packet target row |
| pkt_col_o | output | N*CW | Per-node packet target column |
| arrive_o | output | N | One-cycle pulse per delivered packet at its target node |

## Verification
Forced orthogonal exchanges and exhaustion of the step limit both need disabled bits, and a limit is only reached when some target cannot be reached. The bench therefore walls off a corner node by disabling the two links into it and sends a packet toward that corner. It then checks the exact cycle in which done rises, and that one packet is left. While that run is in progress it also drives load and start, to show that both are ignored. A sweep over every source and target pair on an open 4x4 grid checks that each packet is delivered exactly once at the right node.

// File: rtl/ctr_mesh_pkg.sv
package ctr_mesh_pkg;

    // Schedule phases, one per clock while running
    typedef enum logic [1:0] {
        PH_UP    = 2'd0,   // odd rows with row above
        PH_RIGHT = 2'd1,   // odd columns with column to the right
        PH_DOWN  = 2'd2,   // odd rows with row below
        PH_LEFT  = 2'd3    // odd columns with column to the left
    } phase_e;

    // Disabled-neighbour bit positions
    localparam int DIS_N = 0;
    localparam int DIS_E = 1;
    localparam int DIS_S = 2;
    localparam int DIS_W = 3;

endpackage

// File: rtl/ctr_xchg_cell.sv
// Compare-exchange element for one pair of adjacent nodes.
module ctr_xchg_cell #(
    parameter int RW     = 2,
    parameter int CW     = 2,
    parameter bit VERT   = 1'b1,
    parameter int LO_POS = 0,
    localparam int PW    = 1 + RW + CW,
    localparam int AXW   = (RW > CW) ? RW : CW
) (
    input  logic [PW-1:0] lo_i,
    input  logic [PW-1:0] hi_i,
    input  logic          blk_i,
    input  logic          frc_i,
    output logic [PW-1:0] lo_o,
    output logic [PW-1:0] hi_o
);
    localparam logic [AXW:0] LOP = (AXW+1)'(LO_POS);

    logic           va, vb, same, want;
    logic [AXW-1:0] ta, tb;

    always_comb begin
        va = lo_i[PW-1];
        vb = hi_i[PW-1];
        if (VERT) begin
            ta = AXW'(lo_i[RW+CW-1:CW]);
            tb = AXW'(hi_i[RW+CW-1:CW]);
        end else begin
            ta = AXW'(lo_i[CW-1:0]);
            tb = AXW'(hi_i[CW-1:0]);
        end
        same = va && vb && (lo_i[PW-2:0] == hi_i[PW-2:0]);
        if (va && vb)  want = ({1'b0, ta} > {1'b0, tb});
        else if (va)   want = ({1'b0, ta} > LOP);
        else if (vb)   want = ({1'b0, tb} <= LOP);
        else           want = 1'b0;

        lo_o = lo_i;
        hi_o = hi_i;
        if (!blk_i) begin
            if (same) begin
                lo_o = '0;
                hi_o = '0;
            end else if (frc_i || want) begin
                lo_o = hi_i;
                hi_o = lo_i;
            end
        end

        if (!$isunknown({lo_i, hi_i, blk_i, frc_i})) begin
            assert_pair_no_spawn_R6: assert ($countones({lo_o[PW-1], hi_o[PW-1]})
                                             <= $countones({va, vb}))
                else $error("pair created a packet");
        end
    end

endmodule

// File: rtl/ctr_mesh_ctl.sv
// Run control: start, phase rotation, step limit, done.
module ctr_mesh_ctl
    import ctr_mesh_pkg::*;
#(
    parameter int MAX_STEPS = 64,
    localparam int CNTW     = $clog2(MAX_STEPS + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  logic   start_i,
    input  logic   any_valid_i,
    output logic   run_o,
    output logic   step_o,
    output phase_e phase_o,
    output logic   done_o
);
    typedef struct packed {
        logic            run;
        logic            done;
        phase_e          ph;
        logic [CNTW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic step_d;

    always_comb begin
        ctl_d  = ctl_q;
        step_d = 1'b0;
        if (!ctl_q.run) begin
            if (load_i) begin
                ctl_d.done = 1'b0;
            end else if (start_i) begin
                ctl_d.run  = 1'b1;
                ctl_d.done = 1'b0;
                ctl_d.cnt  = '0;
                ctl_d.ph   = PH_UP;
            end
        end else if (!any_valid_i || ctl_q.cnt == CNTW'(MAX_STEPS)) begin
            ctl_d.run  = 1'b0;
            ctl_d.done = 1'b1;
        end else begin
            step_d    = 1'b1;
            ctl_d.ph  = phase_e'(ctl_q.ph + 2'd1);
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b0, done: 1'b0, ph: PH_UP, cnt: '0};
        else        ctl_q <= ctl_d;
    end

    assign run_o   = ctl_q.run;
    assign step_o  = step_d;
    assign phase_o = ctl_q.ph;
    assign done_o  = ctl_q.done;

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.done && ctl_q.run));

    assert_step_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNTW'(MAX_STEPS));

    assert_phase_rotates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_d |=> (ctl_q.ph == phase_e'($past(ctl_q.ph) + 2'd1)));

endmodule

// File: rtl/ctr_mesh_router.sv
// Clockwise transposition router over a ROWS x COLS grid.
module ctr_mesh_router
    import ctr_mesh_pkg::*;
#(
    parameter int ROWS      = 4,
    parameter int COLS      = 4,
    parameter int MAX_STEPS = 64,
    localparam int N        = ROWS * COLS,
    localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW       = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int PW       = 1 + RW + CW,
    localparam int NV       = (ROWS - 1) * COLS,
    localparam int NH       = ROWS * (COLS - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [N-1:0]    ld_valid_i,
    input  logic [N*RW-1:0] ld_row_i,
    input  logic [N*CW-1:0] ld_col_i,
    input  logic [4*N-1:0]  ld_dis_i,
    input  logic            start_i,
    output logic            done_o,
    output logic [N-1:0]    pkt_valid_o,
    output logic [N*RW-1:0] pkt_row_o,
    output logic [N*CW-1:0] pkt_col_o,
    output logic [N-1:0]    arrive_o
);
    typedef struct packed {
        logic [N-1:0][PW-1:0] pkt;
        logic [N-1:0][3:0]    dis;
        logic [N-1:0]         arr;
    } mesh_t;

    mesh_t mesh_d, mesh_q;

    logic   run, step, any_valid;
    phase_e phase;

    logic [PW-1:0] surv [N];
    logic [N-1:0]  hit;
    logic [PW-1:0] vlo [NV];
    logic [PW-1:0] vhi [NV];
    logic [PW-1:0] hlo [NH];
    logic [PW-1:0] hhi [NH];
    logic [PW-1:0] sel_up [N];
    logic [PW-1:0] sel_dn [N];
    logic [PW-1:0] sel_rt [N];
    logic [PW-1:0] sel_lf [N];

    ctr_mesh_ctl #(.MAX_STEPS(MAX_STEPS)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .start_i    (start_i),
        .any_valid_i(any_valid),
        .run_o      (run),
        .step_o     (step),
        .phase_o    (phase),
        .done_o     (done_o)
    );

    // Per-node delivery check and phase-indexed neighbour selection
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int I = r * COLS + c;

            assign hit[I]  = mesh_q.pkt[I][PW-1]
                          && (mesh_q.pkt[I][RW+CW-1:CW] == RW'(r))
                          && (mesh_q.pkt[I][CW-1:0] == CW'(c));
            assign surv[I] = hit[I] ? '0 : mesh_q.pkt[I];

            // Up phase: pairs whose upper row is even
            if (r % 2 == 0) begin : g_up
                if (r < ROWS - 1) begin : g_lo
                    assign sel_up[I] = vlo[r*COLS+c];
                end else begin : g_none
                    assign sel_up[I] = surv[I];
                end
            end else begin : g_up_hi
                assign sel_up[I] = vhi[(r-1)*COLS+c];
            end

            // Down phase: pairs whose upper row is odd
            if (r % 2 == 1) begin : g_dn
                if (r < ROWS - 1) begin : g_lo
                    assign sel_dn[I] = vlo[r*COLS+c];
                end else begin : g_none
                    assign sel_dn[I] = surv[I];
                end
            end else if (r >= 1) begin : g_dn_hi
                assign sel_dn[I] = vhi[(r-1)*COLS+c];
            end else begin : g_dn_none
                assign sel_dn[I] = surv[I];
            end

            // Right phase: pairs whose left column is odd
            if (c % 2 == 1) begin : g_rt
                if (c < COLS - 1) begin : g_lo
                    assign sel_rt[I] = hlo[r*(COLS-1)+c];
                end else begin : g_none
                    assign sel_rt[I] = surv[I];
                end
            end else if (c >= 1) begin : g_rt_hi
                assign sel_rt[I] = hhi[r*(COLS-1)+c-1];
            end else begin : g_rt_none
                assign sel_rt[I] = surv[I];
            end

            // Left phase: pairs whose left column is even
            if (c % 2 == 0) begin : g_lf
                if (c < COLS - 1) begin : g_lo
                    assign sel_lf[I] = hlo[r*(COLS-1)+c];
                end else begin : g_none
                    assign sel_lf[I] = surv[I];
                end
            end else begin : g_lf_hi
                assign sel_lf[I] = hhi[r*(COLS-1)+c-1];
            end

            assign pkt_valid_o[I]        = mesh_q.pkt[I][PW-1];
            assign pkt_row_o[I*RW +: RW] = mesh_q.pkt[I][RW+CW-1:CW];
            assign pkt_col_o[I*CW +: CW] = mesh_q.pkt[I][CW-1:0];
        end
    end

    // Vertical compare-exchange cells, one per vertical link
    for (genvar r = 0; r < ROWS - 1; r++) begin : g_vp_row
        for (genvar c = 0; c < COLS; c++) begin : g_vp_col
            localparam int A = r * COLS + c;
            localparam int B = (r + 1) * COLS + c;
            ctr_xchg_cell #(.RW(RW), .CW(CW), .VERT(1'b1), .LO_POS(r)) u_cell (
                .lo_i (surv[A]),
                .hi_i (surv[B]),
                .blk_i(mesh_q.dis[A][DIS_S] | mesh_q.dis[B][DIS_N]),
                .frc_i(mesh_q.dis[A][DIS_E] | mesh_q.dis[A][DIS_W]
                     | mesh_q.dis[B][DIS_E] | mesh_q.dis[B][DIS_W]),
                .lo_o (vlo[A]),
                .hi_o (vhi[A])
            );
        end
    end

    // Horizontal compare-exchange cells, one per horizontal link
    for (genvar r = 0; r < ROWS; r++) begin : g_hp_row
        for (genvar c = 0; c < COLS - 1; c++) begin : g_hp_col
            localparam int A = r * COLS + c;
            localparam int K = r * (COLS - 1) + c;
            ctr_xchg_cell #(.RW(RW), .CW(CW), .VERT(1'b0), .LO_POS(c)) u_cell (
                .lo_i (surv[A]),
                .hi_i (surv[A+1]),
                .blk_i(mesh_q.dis[A][DIS_E] | mesh_q.dis[A+1][DIS_W]),
                .frc_i(mesh_q.dis[A][DIS_N] | mesh_q.dis[A][DIS_S]
                     | mesh_q.dis[A+1][DIS_N] | mesh_q.dis[A+1][DIS_S]),
                .lo_o (hlo[K]),
                .hi_o (hhi[K])
            );
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < N; i++) any_valid = any_valid | mesh_q.pkt[i][PW-1];
    end

    always_comb begin
        mesh_d     = mesh_q;
        mesh_d.arr = '0;
        if (load_i && !run) begin
            for (int i = 0; i < N; i++) begin
                mesh_d.pkt[i] = ld_valid_i[i]
                              ? {1'b1, ld_row_i[i*RW +: RW], ld_col_i[i*CW +: CW]}
                              : '0;
                mesh_d.dis[i] = ld_dis_i[i*4 +: 4];
            end
        end else if (step) begin
            mesh_d.arr = hit;
            for (int i = 0; i < N; i++) begin
                unique case (phase)
                    PH_UP:    mesh_d.pkt[i] = sel_up[i];
                    PH_RIGHT: mesh_d.pkt[i] = sel_rt[i];
                    PH_DOWN:  mesh_d.pkt[i] = sel_dn[i];
                    PH_LEFT:  mesh_d.pkt[i] = sel_lf[i];
                    default:  mesh_d.pkt[i] = surv[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mesh_q <= '0;
        else        mesh_q <= mesh_d;
    end

    assign arrive_o = mesh_q.arr;

    assert_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step) |-> ($countones(pkt_valid_o) <= $countones($past(pkt_valid_o))));

    assert_dis_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(mesh_q.dis));

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_arrive_from_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            arrive_o[i] |-> ($past(step) && $past(pkt_valid_o[i])));
    end

endmodule

// File: tb/sim_ctr_mesh_router.sv
`timescale 1ns/1ps
module sim_ctr_mesh_router;
    localparam int ROWS = 4, COLS = 4, MAXS = 40;
    localparam int N = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0, start_i = 1'b0;
    logic [N-1:0]   ldv = '0;
    logic [2*N-1:0] ldr = '0, ldc = '0;
    logic [4*N-1:0] ldd = '0;
    logic done_o;
    logic [N-1:0]   pv, arrive_o;
    logic [2*N-1:0] pr, pc;

    int checks = 0, fails = 0, wd = 0;
    int k, done_cyc;
    int arr_cnt [N];
    int arr_cyc [N];

    always #5 clk = ~clk;

    ctr_mesh_router #(.ROWS(ROWS), .COLS(COLS), .MAX_STEPS(MAXS)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ld_valid_i(ldv),
        .ld_row_i(ldr), .ld_col_i(ldc), .ld_dis_i(ldd), .start_i(start_i),
        .done_o(done_o), .pkt_valid_o(pv), .pkt_row_o(pr), .pkt_col_o(pc),
        .arrive_o(arrive_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; fails++;
            $display("FAIL R10 watchdog expired: actual %0d cycles expected below 150000", wd);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ix(input int r, input int c);
        return r * COLS + c;
    endfunction

    task automatic clr_ld();
        ldv = '0; ldr = '0; ldc = '0; ldd = '0;
    endtask

    task automatic put(input int i, input int tr, input int tc);
        ldv[i] = 1'b1; ldr[i*2 +: 2] = 2'(tr); ldc[i*2 +: 2] = 2'(tc);
    endtask

    task automatic do_load();
        @(negedge clk); load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic begin_run();
        @(negedge clk); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
        k = 0; done_cyc = 0;
        for (int i = 0; i < N; i++) begin arr_cnt[i] = 0; arr_cyc[i] = 0; end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        k++;
        for (int i = 0; i < N; i++)
            if (arrive_o[i]) begin
                arr_cnt[i]++;
                if (arr_cyc[i] == 0) arr_cyc[i] = k;
            end
        if (done_o && done_cyc == 0) done_cyc = k;
    endtask

    task automatic finish_run();
        for (int g = 0; g < 200 && done_cyc == 0; g++) tick();
    endtask

    function automatic int pkt_of(input int i);
        return pv[i] ? (pr[i*2 +: 2] * 4 + pc[i*2 +: 2]) : -1;
    endfunction

    function automatic int total_arr();
        int s = 0;
        for (int i = 0; i < N; i++) s += arr_cnt[i];
        return s;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pv == '0, "R1 nodes null after reset", int'($countones(pv)), 0);
        check(!done_o, "R1 done low after reset", int'(done_o), 0);
        check(arrive_o == '0, "R1 no arrival after reset", int'($countones(arrive_o)), 0);

        // R2: load reflected at outputs
        clr_ld(); put(ix(2,1), 3, 2); put(ix(0,3), 1, 0); do_load();
        check(pkt_of(ix(2,1)) == 14 && pkt_of(ix(0,3)) == 4 && $countones(pv) == 2,
              "R2 loaded packets visible", pkt_of(ix(2,1)), 14);

        // R3 R5 R7: (0,0)->(0,1) moves only in the left phase, arrival at step 5
        clr_ld(); put(ix(0,0), 0, 1); do_load();
        begin_run(); finish_run();
        check(arr_cyc[1] == 5 && arr_cnt[1] == 1, "R7 arrival cycle at node 1", arr_cyc[1], 5);
        check(done_cyc == 6, "R10 done after empty grid", done_cyc, 6);
        check(!done_o || pv == '0, "R10 grid empty at done", int'($countones(pv)), 0);

        // R3 R5: (1,0)->(0,0) moves in the up phase
        clr_ld(); put(ix(1,0), 0, 0); do_load();
        begin_run(); finish_run();
        check(arr_cyc[0] == 2 && done_cyc == 3, "R3 up phase first", arr_cyc[0], 2);

        // R3 R5: (1,0)->(2,0) waits for the down phase
        clr_ld(); put(ix(1,0), 2, 0); do_load();
        begin_run(); finish_run();
        check(arr_cyc[ix(2,0)] == 4 && done_cyc == 5, "R3 down phase third", arr_cyc[ix(2,0)], 4);

        // R6: identical targets cancel
        clr_ld(); put(ix(0,0), 3, 3); put(ix(1,0), 3, 3); do_load();
        begin_run(); tick();
        check(pv == '0, "R6 pair cancelled", int'($countones(pv)), 0);
        finish_run();
        check(done_cyc == 2 && total_arr() == 0, "R6 no arrival after cancel", done_cyc, 2);

        // R8: blocked pair does not cancel
        clr_ld(); put(ix(0,0), 3, 3); put(ix(1,0), 3, 3); ldd[ix(1,0)*4 + 0] = 1'b1; do_load();
        begin_run(); tick();
        check(pkt_of(ix(0,0)) == 15 && pkt_of(ix(1,0)) == 15, "R8 blocked pair kept", int'($countones(pv)), 2);
        finish_run();

        // R4: swap when upper target row greater
        clr_ld(); put(ix(0,0), 2, 3); put(ix(1,0), 0, 2); do_load();
        begin_run(); tick();
        check(pkt_of(ix(0,0)) == 2 && pkt_of(ix(1,0)) == 11, "R4 swap on greater row", pkt_of(ix(0,0)), 2);
        finish_run();

        // R4: no swap when target rows equal
        clr_ld(); put(ix(0,0), 1, 1); put(ix(1,0), 1, 3); do_load();
        begin_run(); tick();
        check(pkt_of(ix(0,0)) == 5 && pkt_of(ix(1,0)) == 7, "R4 hold on equal rows", pkt_of(ix(0,0)), 5);
        finish_run();

        // R5 control: packet at (0,2) to (0,3) does not move left
        clr_ld(); put(ix(0,2), 0, 3); do_load();
        begin_run(); tick(); tick();
        check(pkt_of(ix(0,2)) == 3 && !pv[ix(0,1)], "R5 no move away from target", pkt_of(ix(0,2)), 3);
        finish_run();

        // R9: south-disabled bit at (0,1) forces the horizontal exchange
        clr_ld(); put(ix(0,2), 0, 3); ldd[ix(0,1)*4 + 2] = 1'b1; do_load();
        begin_run(); tick();
        check(pkt_of(ix(0,2)) == 3, "R9 no vertical move first", pkt_of(ix(0,2)), 3);
        tick();
        check(pkt_of(ix(0,1)) == 3 && !pv[ix(0,2)], "R9 forced swap", pkt_of(ix(0,1)), 3);
        finish_run();

        // R11 R12: walled corner, limit reached, load/start ignored mid-run
        clr_ld(); put(ix(1,1), 0, 0);
        ldd[ix(0,1)*4 + 3] = 1'b1; ldd[ix(1,0)*4 + 0] = 1'b1; do_load();
        begin_run();
        for (int j = 0; j < 10; j++) tick();
        clr_ld(); load_i = 1'b1; start_i = 1'b1;
        tick();
        load_i = 1'b0; start_i = 1'b0;
        finish_run();
        check(done_cyc == MAXS + 1, "R11 done at step limit", done_cyc, MAXS + 1);
        check($countones(pv) == 1 && total_arr() == 0, "R12 load ignored while running",
              int'($countones(pv)), 1);

        // R2: load clears done
        clr_ld(); put(ix(3,3), 0, 0); do_load();
        check(!done_o && pkt_of(ix(3,3)) == 0, "R2 load clears done", int'(done_o), 0);

        // R5 R7: every source to every target on the open grid
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                clr_ld(); put(s, d / COLS, d % COLS); do_load();
                begin_run(); finish_run();
                check(arr_cnt[d] == 1 && total_arr() == 1 && done_cyc >= 1 && done_cyc <= MAXS
                      && pv == '0, "R7 sweep delivered once at target", s * N + d, arr_cnt[d]);
            end
        end

        summary();
        $finish;
    end
endmodule